// File: doc/BRIEF.md
# Double-Data-Rate Output Stage with Enable Freeze

The block turns two parallel words per clock cycle into one output that changes on both clock edges. Both words are captured together on the rising edge. The output then shows the first word while the clock is high and the second word while the clock is low. A synchronous enable and a synchronous reset control the stage.

Enable and reset follow an asymmetric edge rule. A drop of the enable, or a rise of the reset, already acts at the falling edge. The return of the enable, or the release of the reset, is only recognised at a rising edge.

A parameter picks what the output does while the enable is low:
- In freeze mode the output stays on the last captured first-half word.
- In generic mode the output keeps alternating between the two held words.

Top module: `ddr_freeze_out`

## Requirements
- R1: When `rst` is low and `en` is high at a rising edge, `d_rise` and `d_fall` are both captured at that edge.
- R2: While enabled, `q` equals the captured `d_rise` word while `clk` is high and the captured `d_fall` word while `clk` is low.
- R3: When `en` is low at a rising edge (and `rst` is low), neither captured word changes at that edge.
- R4: With `FREEZE` = 1, if `en` is low at a falling edge, `q` shows the captured rising word during the low phase that follows, so `q` stays constant.
- R5: With `FREEZE` = 1, the falling-half word returns to `q` only after a rising edge at which `en` was high. Enable seen high at a falling edge alone keeps `q` frozen. After that rising edge, the new rising word appears first and the new falling word follows at the next falling edge.
- R6: With `FREEZE` = 0, a low `en` only stops the capture, and `q` keeps alternating between the two held words.
- R7: `rst` high at a falling edge drives `q` to `INIT` for the low phase that follows, in both modes.
- R8: `rst` high at a rising edge loads `INIT` into both captured words. The first rising edge with `rst` low captures normally if `en` is high.
- R9: `en` low at a falling edge but high again at the next rising edge still lets that rising edge capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable, active high |
| d_rise | input | WIDTH | Word shown in the high phase |
| d_fall | input | WIDTH | Word shown in the low phase |
| q | output | WIDTH | Double-rate output |

## Verification
The bench goes after the half-cycle windows where the two edges disagree.

- **Enable dropped in the high phase.** A design that reacted only at the rising edge would still show the falling word in the low phase instead of freezing.
- **Enable raised in the high phase after a low cycle.** A design that reacted at the falling edge would unfreeze half a cycle early and show a stale falling word.
- **Enable low only in the high phase.** This checks that the following rising edge still captures.
- **Reset raised mid-cycle and released.** This checks that `INIT` appears at the falling edge and that capture resumes at the first clean rising edge.
- **Both modes run side by side.** A freeze that leaks into generic mode shows up at once.

// File: rtl/ddr_out_pkg.sv
package ddr_out_pkg;
  typedef enum logic { MODE_GENERIC = 1'b0, MODE_FREEZE = 1'b1 } ddr_mode_e;

  // decides whether the low phase shows the falling word (1) or the rising word (0)
  function automatic logic show_fall(ddr_mode_e mode, logic en_now, logic live);
    return (mode == MODE_GENERIC) || (en_now && live);
  endfunction
endpackage

// File: rtl/ddr_cap_stage.sv
module ddr_cap_stage #(
  parameter int WIDTH = 9,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d_rise,
  input  logic [WIDTH-1:0] d_fall,
  output logic [WIDTH-1:0] rise_q,
  output logic [WIDTH-1:0] fall_w,
  output logic             live
);
  logic load_ev;
  assign load_ev = en && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= INIT;
      fall_w <= INIT;
      live   <= 1'b0;
    end else begin
      live <= en;
      if (load_ev) begin
        rise_q <= d_rise;
        fall_w <= d_fall;
      end
    end
  end

  // R1
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (rise_q == $past(d_rise)) && (fall_w == $past(d_fall)));
  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rise_q) && $stable(fall_w));
  // R8
  cap_reset_chk: assert property (@(posedge clk)
    rst |=> (rise_q == INIT) && (fall_w == INIT) && !live);
endmodule

// File: rtl/ddr_fall_stage.sv
module ddr_fall_stage
  import ddr_out_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter logic [WIDTH-1:0] INIT = '0,
  parameter ddr_mode_e MODE = MODE_FREEZE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             live,
  input  logic [WIDTH-1:0] rise_q,
  input  logic [WIDTH-1:0] fall_w,
  output logic [WIDTH-1:0] fall_q
);
  logic pick_fall;
  assign pick_fall = show_fall(MODE, en, live);

  always_ff @(negedge clk) begin
    if (rst)            fall_q <= INIT;
    else if (pick_fall) fall_q <= fall_w;
    else                fall_q <= rise_q;
  end

  generate
    if (MODE == MODE_FREEZE) begin : g_frz_chk
      // R4
      freeze_hold_chk: assert property (@(negedge clk) disable iff (rst)
        !en |=> fall_q == $past(rise_q));
    end else begin : g_gen_chk
      // R6
      generic_alt_chk: assert property (@(negedge clk) disable iff (rst)
        !en |=> fall_q == $past(fall_w));
    end
  endgenerate

  // R7
  fall_reset_chk: assert property (@(negedge clk) rst |=> fall_q == INIT);
endmodule

// File: rtl/ddr_edge_mux.sv
module ddr_edge_mux #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] rise_q,
  input  logic [WIDTH-1:0] fall_q,
  output logic [WIDTH-1:0] q
);
  assign q = clk ? rise_q : fall_q;
endmodule

// File: rtl/ddr_freeze_out.sv
module ddr_freeze_out
  import ddr_out_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter logic [WIDTH-1:0] INIT = '0,
  parameter bit FREEZE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d_rise,
  input  logic [WIDTH-1:0] d_fall,
  output logic [WIDTH-1:0] q
);
  localparam ddr_mode_e MODE = FREEZE ? MODE_FREEZE : MODE_GENERIC;

  logic [WIDTH-1:0] rise_q, fall_w, fall_q;
  logic             live;

  ddr_cap_stage #(.WIDTH(WIDTH), .INIT(INIT)) u_cap (
    .clk(clk), .rst(rst), .en(en), .d_rise(d_rise), .d_fall(d_fall),
    .rise_q(rise_q), .fall_w(fall_w), .live(live));

  ddr_fall_stage #(.WIDTH(WIDTH), .INIT(INIT), .MODE(MODE)) u_fall (
    .clk(clk), .rst(rst), .en(en), .live(live),
    .rise_q(rise_q), .fall_w(fall_w), .fall_q(fall_q));

  ddr_edge_mux #(.WIDTH(WIDTH)) u_mux (
    .clk(clk), .rise_q(rise_q), .fall_q(fall_q), .q(q));

  // R2
  high_phase_chk: assert property (@(negedge clk) disable iff (rst)
    1'b1 |-> q == rise_q);
endmodule

// File: tb/ddr_freeze_out_tb.sv
module ddr_freeze_out_tb;
  localparam int W = 9;
  localparam logic [W-1:0] INITV = 9'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [W-1:0] dr = 9'd100;
  logic [W-1:0] df = 9'd200;
  logic [W-1:0] q_frz, q_gen;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] mr, mf, mq_frz, mq_gen;
  logic mlive;

  always #10 clk = ~clk;   // 50 MHz

  ddr_freeze_out #(.WIDTH(W), .INIT(INITV), .FREEZE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .en(en), .d_rise(dr), .d_fall(df), .q(q_frz));
  ddr_freeze_out #(.WIDTH(W), .INIT(INITV), .FREEZE(1'b0)) u_dut_gen (
    .clk(clk), .rst(rst), .en(en), .d_rise(dr), .d_fall(df), .q(q_gen));

  function automatic logic [W-1:0] low_word(bit frz, logic r, logic e, logic lv,
                                            logic [W-1:0] wr, logic [W-1:0] wf);
    if (r) return INITV;
    if (!frz) return wf;
    return (e && lv) ? wf : wr;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // one clock cycle: en/rst for the high phase (a) and the low phase (b)
  task automatic cyc(logic ea, logic ra, logic eb, logic rb, string req);
    @(posedge clk);
    if (rst) begin mr = INITV; mf = INITV; mlive = 1'b0; end
    else begin
      mlive = en;
      if (en) begin mr = dr; mf = df; end
    end
    #2;
    en = ea; rst = ra; dr = dr + 1'b1; df = df + 1'b1;
    #5;
    check({req, " R1 R2 R3 R8 high"}, q_frz, mr);
    check({req, " R6 high gen"}, q_gen, mr);
    @(negedge clk);
    mq_frz = low_word(1'b1, rst, en, mlive, mr, mf);
    mq_gen = low_word(1'b0, rst, en, mlive, mr, mf);
    #2;
    en = eb; rst = rb;
    #5;
    check({req, " R4 R5 R7 R9 low frz"}, q_frz, mq_frz);
    check({req, " R6 R7 low gen"}, q_gen, mq_gen);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed = 17;
    logic e1, e2, r1;
    mr = INITV; mf = INITV; mlive = 1'b0;
    void'($urandom(seed));

    // reset state (R8, R7)
    repeat (3) cyc(1'b0, 1'b1, 1'b0, 1'b1, "reset");
    // release with enable (R8), steady running (R1, R2)
    repeat (4) cyc(1'b1, 1'b0, 1'b1, 1'b0, "run");
    // enable dropped in the high phase (R4, R6, R3)
    repeat (4) cyc(1'b0, 1'b0, 1'b0, 1'b0, "drop");
    // enable raised in the high phase: still frozen this cycle (R5)
    cyc(1'b1, 1'b0, 1'b1, 1'b0, "rearm");
    repeat (3) cyc(1'b1, 1'b0, 1'b1, 1'b0, "resume");
    // enable low only in the high phase (R9)
    repeat (3) cyc(1'b0, 1'b0, 1'b1, 1'b0, "blip");
    // reset raised mid-cycle, then released (R7, R8)
    cyc(1'b1, 1'b1, 1'b1, 1'b1, "rst mid");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "rst rel");
    repeat (3) cyc(1'b1, 1'b0, 1'b1, 1'b0, "post rst");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      e1 = ($urandom % 4) != 0;
      e2 = ($urandom % 4) != 0;
      r1 = ($urandom % 32) == 0;
      cyc(e1, r1, e2, r1 && (($urandom % 2) == 0), "random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule